// File: doc/BRIEF.md
# Row Skip Pre-Processor for a 1D Transform Stage

This block sits directly in front of an 8-point one-dimensional forward or inverse DCT stage. It receives one row of eight signed samples per valid cycle and computes two statistics for that row. The first is the leading sample. The second is the sum of absolute differences between neighbouring samples. From these two values a heuristic decides whether the row carries so little energy that the quantizer would most likely discard its transform anyway.

When a row is judged skippable, the block presents eight zero samples and raises a skip flag, so the downstream transform can stay idle for that row. Otherwise the row is forwarded unchanged with the flag low. The same decision rule is used in both transform directions and in front of each of the three passes of a separable 3D transform. A mode bit travels alongside the row for the transform's use. A running count of skipped rows lets the achieved computation saving be measured.

Top module: `dct_row_skip`

## Requirements
- R1: After a clock edge with `rst_n` low, `out_valid`, `out_skip`, `out_mode`, `out_row` and `skip_count` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high (one register of latency), and low after a cycle with `in_valid` low.
- R3: Samples are signed two's complement, with sample k at bits [k*W +: W] of `in_row` and `out_row`. The leading value is sample 0. The statistic is the sum over k=0..6 of |sample k+1 - sample k|, computed without overflow for any sample values.
- R4: A row whose leading sample is zero and whose difference sum is zero (an all-zero row) is skipped: `out_skip` is 1 and `out_row` is all zeros.
- R5: A row whose leading sample is zero but whose difference sum is nonzero is never skipped, whatever `threshold` holds; it is forwarded bit-exact with `out_skip` 0.
- R6: A row with a nonzero leading sample and a difference sum strictly below the unsigned 12-bit `threshold` is skipped: `out_skip` is 1 and `out_row` is all zeros.
- R7: A row with a nonzero leading sample and a difference sum greater than or equal to `threshold` is forwarded bit-exact with `out_skip` 0; with `threshold` 0 such a row is never skipped.
- R8: `mode` (0 forward, 1 inverse) does not affect the decision; `out_mode` reproduces the `mode` of the row it accompanies.
- R9: `skip_count` increases by exactly one, modulo 2^CNT_W, in the same cycle that a row appears with `out_skip` 1, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A row is present on `in_row` |
| in_row | input | N*W (96) | Eight signed samples, sample k at [k*W +: W] |
| mode | input | 1 | Transform direction: 0 forward, 1 inverse |
| threshold | input | TH_W (12) | Unsigned skip threshold for rows with a nonzero leading sample |
| out_valid | output | 1 | A decided row is present on `out_row` |
| out_row | output | N*W (96) | Forwarded row, or all zeros when skipped |
| out_skip | output | 1 | The row was skipped and zeroed |
| out_mode | output | 1 | Direction bit aligned with `out_row` |
| skip_count | output | CNT_W (16) | Number of skipped rows, wrapping |

## Verification
The rule is exercised with all-zero rows, rows that start with zero but vary later, and smooth rows with a nonzero start placed one below, exactly at and above the threshold. These separate the two skip conditions from each other and pin down the strict comparison. Rows alternating between the most negative and most positive sample test the width of the statistic: a sum truncated to the threshold width would wrap below 4095 and wrongly skip. Back-to-back rows with both mode values, idle gaps and a zero threshold show that direction never alters the decision, that latency and counting hold under streaming, and that a zero threshold disables the second skip condition.

// File: rtl/dcs_pkg.sv
// Package: shared encodings for the row skip pre-processor.
// Assumes: nothing beyond IEEE 1800-2017.
package dcs_pkg;

    // Transform direction carried alongside each row.
    typedef enum logic {
        XF_FORWARD = 1'b0,
        XF_INVERSE = 1'b1
    } xf_dir_e;

    // Width needed to hold a sum of N-1 absolute differences of W-bit signed samples.
    function automatic int sad_width(input int w, input int n);
        return w + 1 + $clog2(n - 1);
    endfunction

endpackage

// File: rtl/dcs_row_stats.sv
// Module: dcs_row_stats
// Computes, combinationally, whether the leading sample of a row is nonzero
// and the sum of absolute differences between neighbouring samples.
// Assumes: samples are signed two's complement, sample k at [k*W +: W];
// SAD_W is large enough for (N-1) * (2^W - 1).
module dcs_row_stats #(
    parameter int N     = 8,
    parameter int W     = 12,
    parameter int SAD_W = 16
) (
    input  logic [N*W-1:0]   row,
    output logic             lead_nz,
    output logic [SAD_W-1:0] sad
);

    logic [W:0] mag [N-1];

    // Leading term test on sample 0.
    assign lead_nz = |row[W-1:0];

    // One magnitude unit per neighbouring pair.
    for (genvar k = 0; k < N - 1; k++) begin : g_pair
        logic signed [W:0] lo_s;
        logic signed [W:0] hi_s;
        logic signed [W:0] diff;
        assign lo_s = {row[k*W + W-1], row[k*W +: W]};
        assign hi_s = {row[(k+1)*W + W-1], row[(k+1)*W +: W]};
        assign diff = hi_s - lo_s;
        // Absolute value, fits in W+1 bits because |diff| <= 2^W - 1.
        assign mag[k] = diff[W] ? (~diff + 1'b1) : diff;
    end

    // Accumulate the pair magnitudes at full width.
    always_comb begin
        sad = '0;
        for (int k = 0; k < N - 1; k++) begin
            sad = sad + {{(SAD_W-W-1){1'b0}}, mag[k]};
        end
    end

endmodule

// File: rtl/dcs_skip_decide.sv
// Module: dcs_skip_decide
// Applies the skip heuristic: an all-zero row, or a row with a nonzero
// leading sample whose difference sum is strictly below the threshold.
// Assumes: SAD_W > TH_W, threshold is unsigned.
module dcs_skip_decide #(
    parameter int SAD_W = 16,
    parameter int TH_W  = 12
) (
    input  logic             lead_nz,
    input  logic [SAD_W-1:0] sad,
    input  logic [TH_W-1:0]  threshold,
    output logic             skip
);

    logic [SAD_W-1:0] th_ext;
    logic             flat_zero;
    logic             below_th;

    assign th_ext = {{(SAD_W-TH_W){1'b0}}, threshold};

    // Evaluate both skip conditions and combine them.
    always_comb begin
        flat_zero = !lead_nz && (sad == '0);
        below_th  = lead_nz && (sad < th_ext);
        skip      = flat_zero || below_th;
    end

endmodule

// File: rtl/dcs_skip_counter.sv
// Module: dcs_skip_counter
// Counts skipped rows; wraps modulo 2^CNT_W.
// Assumes: inc is a single-cycle strobe per skipped row.
module dcs_skip_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Advance the count on each strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

endmodule

// File: rtl/dct_row_skip.sv
// Module: dct_row_skip (top)
// Pre-processor in front of a 1D DCT/IDCT stage. Decides per row whether the
// transform may be skipped, zeroes skipped rows, and registers the result
// with one cycle of latency together with the skip flag and mode bit.
// Assumes: synchronous active-low reset; one row per valid cycle.
module dct_row_skip
    import dcs_pkg::*;
#(
    parameter int N     = 8,
    parameter int W     = 12,
    parameter int TH_W  = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [N*W-1:0]   in_row,
    input  logic             mode,
    input  logic [TH_W-1:0]  threshold,
    output logic             out_valid,
    output logic [N*W-1:0]   out_row,
    output logic             out_skip,
    output logic             out_mode,
    output logic [CNT_W-1:0] skip_count
);

    localparam int SAD_W = sad_width(W, N);

    logic             lead_nz;
    logic [SAD_W-1:0] sad;
    logic             skip_now;
    xf_dir_e          dir_in;

    assign dir_in = xf_dir_e'(mode);

    dcs_row_stats #(.N(N), .W(W), .SAD_W(SAD_W)) u_stats (
        .row     (in_row),
        .lead_nz (lead_nz),
        .sad     (sad)
    );

    dcs_skip_decide #(.SAD_W(SAD_W), .TH_W(TH_W)) u_decide (
        .lead_nz   (lead_nz),
        .sad       (sad),
        .threshold (threshold),
        .skip      (skip_now)
    );

    dcs_skip_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (in_valid && skip_now),
        .count (skip_count)
    );

    // Output register: forward or zero the row, align flag and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_skip  <= 1'b0;
            out_mode  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_row  <= skip_now ? '0 : in_row;
                out_skip <= skip_now;
                out_mode <= (dir_in == XF_INVERSE);
            end
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_zeroed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_skip) |-> (out_row == '0));

    assert_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !skip_now) |=> (out_row == $past(in_row)));

    assert_lead_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lead_nz && sad != '0) |=> !out_skip);

    assert_mode_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_mode == $past(mode)));

endmodule

// File: tb/dct_row_skip_test.sv
// Scoreboard bench: the driver pushes expected rows, the monitor pops and compares.
module dct_row_skip_test;

    localparam int N = 8;
    localparam int W = 12;

    typedef struct {
        logic [N*W-1:0] row;
        logic           skip;
        logic           mode;
        string          tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [N*W-1:0]  in_row = '0;
    logic            mode = 1'b0;
    logic [11:0]     threshold = '0;
    logic            out_valid;
    logic [N*W-1:0]  out_row;
    logic            out_skip;
    logic            out_mode;
    logic [15:0]     skip_count;

    exp_t  sb[$];
    int    checks = 0;
    int    fails = 0;
    int    pushed = 0;
    int    popped = 0;
    logic  exp_valid = 1'b0;
    logic [15:0] exp_count = '0;
    logic  mon_on = 1'b0;
    logic  done = 1'b0;

    always #5 clk = ~clk;

    dct_row_skip uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row),
        .mode(mode), .threshold(threshold), .out_valid(out_valid),
        .out_row(out_row), .out_skip(out_skip), .out_mode(out_mode),
        .skip_count(skip_count)
    );

    function automatic logic [N*W-1:0] mk(input int s0, s1, s2, s3, s4, s5, s6, s7);
        int s [N];
        logic [N*W-1:0] r;
        s = '{s0, s1, s2, s3, s4, s5, s6, s7};
        for (int k = 0; k < N; k++) r[k*W +: W] = W'(s[k]);
        return r;
    endfunction

    // Reference rule from R3..R7.
    function automatic logic model_skip(input logic [N*W-1:0] r, input int th);
        int sad = 0;
        int a;
        a = int'($signed(r[W-1:0]));
        for (int k = 0; k < N - 1; k++) begin
            int d;
            d = int'($signed(r[(k+1)*W +: W])) - int'($signed(r[k*W +: W]));
            sad += (d < 0) ? -d : d;
        end
        if (a == 0) return (sad == 0);
        return (sad < th);
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [N*W-1:0] r, input int th, input logic m, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_row    = r;
        threshold = 12'(th);
        mode      = m;
        e.skip = model_skip(r, th);
        e.row  = e.skip ? '0 : r;
        e.mode = m;
        e.tag  = tag;
        sb.push_back(e);
        pushed++;
        exp_valid = 1'b1;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            exp_valid = 1'b0;
        end
    endtask

    // Monitor: sample shortly after each rising edge, compare against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                check(out_valid == exp_valid, "R2", "out_valid", 128'(out_valid), 128'(exp_valid));
                if (out_valid && sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    popped++;
                    if (e.skip) exp_count = exp_count + 1'b1;
                    check(out_row == e.row, e.tag, "out_row", 128'(out_row), 128'(e.row));
                    check(out_skip == e.skip, e.tag, "out_skip", 128'(out_skip), 128'(e.skip));
                    check(out_mode == e.mode, "R8", "out_mode", 128'(out_mode), 128'(e.mode));
                    check(skip_count == exp_count, "R9", "skip_count", 128'(skip_count), 128'(exp_count));
                end else if (!out_valid) begin
                    check(skip_count == exp_count, "R9", "skip_count idle", 128'(skip_count), 128'(exp_count));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        in_row = {N{12'hABC}};
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", 128'(out_valid), 128'(0));
        check(out_skip == 1'b0, "R1", "out_skip", 128'(out_skip), 128'(0));
        check(out_mode == 1'b0, "R1", "out_mode", 128'(out_mode), 128'(0));
        check(out_row == '0, "R1", "out_row", 128'(out_row), 128'(0));
        check(skip_count == '0, "R1", "skip_count", 128'(skip_count), 128'(0));
        rst_n = 1'b1;
        in_row = '0;
        mon_on = 1'b1;

        send(mk(0, 0, 0, 0, 0, 0, 0, 0), 0, 1'b0, "R4");          // all zero, th 0
        send(mk(0, 0, 0, 0, 0, 0, 0, 0), 4095, 1'b1, "R4");
        send(mk(0, 1, 0, 0, 0, 0, 0, 0), 4095, 1'b0, "R5");       // sad 2, lead zero
        send(mk(0, 0, 0, 0, 0, 0, 0, -3), 4095, 1'b1, "R5");
        send(mk(5, 6, 6, 6, 6, 6, 6, 6), 2, 1'b0, "R6");          // sad 1 < 2
        send(mk(-7, -7, -8, -8, -8, -8, -8, -6), 4, 1'b1, "R6");  // sad 3 < 4
        idle(2);
        send(mk(5, 6, 6, 6, 6, 6, 6, 6), 1, 1'b0, "R7");          // sad 1 == th
        send(mk(-7, -7, -8, -8, -8, -8, -8, -6), 3, 1'b1, "R7");  // sad 3 == th
        send(mk(100, 90, 80, 70, 60, 50, 40, 30), 69, 1'b0, "R7"); // sad 70 > 69
        send(mk(100, 90, 80, 70, 60, 50, 40, 30), 71, 1'b0, "R6"); // sad 70 < 71
        send(mk(1, 1, 1, 1, 1, 1, 1, 1), 0, 1'b1, "R7");          // th 0 never skips
        // R3: extremes, sad 28665; truncated to 12 bits would be 4089 < 4095
        send(mk(-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047), 4095, 1'b0, "R3");
        send(mk(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2046), 2, 1'b1, "R3");
        send(mk(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048), 1, 1'b0, "R3");
        // R8: identical row in both directions
        send(mk(3, 3, 4, 4, 4, 4, 4, 4), 2, 1'b0, "R8");
        send(mk(3, 3, 4, 4, 4, 4, 4, 4), 2, 1'b1, "R8");
        send(mk(3, 3, 4, 4, 4, 4, 4, 4), 1, 1'b0, "R8");
        send(mk(3, 3, 4, 4, 4, 4, 4, 4), 1, 1'b1, "R8");
        idle(1);
        // Streaming mix for R9
        for (int i = 0; i < 40; i++) begin
            send(mk(i % 3, i % 5, 2, 2, 2, 2, 2, (i % 4) - 2), (i * 37) % 20, 1'(i), "R9");
        end
        idle(3);
        check(popped == pushed, "R2", "rows delivered", 128'(popped), 128'(pushed));
        check(sb.size() == 0, "R2", "queue empty", 128'(sb.size()), 128'(0));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule